// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and arithmetic half of a 32-bit processor built around one shared internal bus. It holds the program counter, the instruction register, a file of general-purpose registers, the memory address and memory data registers, an operand staging register (Y), a result register (Z) and the zero and negative flags. It has no sequencer of its own. An external control unit supplies one flat control word per clock. Within that word, a set of source strobes picks the single register that drives the bus, and a set of load strobes picks the registers that capture the bus at the next rising edge.

All arithmetic takes two bus transfers. The first moves one operand into Y. Alternatively, the operand-select bit replaces Y with the constant four. The second places the other operand on the bus while the ALU result is written to Z. A later cycle then moves Z back onto the bus. The flags load from the ALU result under their own strobe, so a compare is simply a subtraction with the flag strobe set and no Z load. A sign-extended immediate field of the instruction register can also drive the bus, which serves immediate loads and relative branch targets.

Top module: `sbus_datapath`

## Requirements
- R1: The control word is laid out as follows. The source strobes occupy bits 0 to 4: PC, IR offset, MDR, Z, GPR. The load strobes occupy bits 5 to 12: PC, IR, MAR, MDR from bus, MDR from memory, Y, Z, GPR. Bit 13 selects the constant 4 in place of Y. Bit 14 loads the flags. Bit 15 requests a read and bit 16 requests a write. Bits 19:17 hold the ALU code, bits 24:20 hold the GPR source index and bits 29:25 hold the GPR destination index.
- R2: `bus_mon` shows the bus in the same cycle. Its value comes from the one source strobe that is active. For the IR offset source it is IR[15:0] sign-extended to 32 bits. It is zero when no source strobe is active.
- R3: The ALU takes operand A from Y, or the constant 4 when bit 13 is set, and operand B from the bus. The ALU codes are: 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 B+1, 5 NOT B, 6 B shifted left one place with a 0 entering bit 0, and 7 B passed through.
- R4: Z loads the ALU result only when its load strobe is set. It holds its value otherwise, and it reaches the bus only through its source strobe.
- R5: When bit 14 is set, the zero flag becomes (ALU result == 0) and the negative flag becomes ALU result bit 31. Otherwise both flags hold. A compare (bit 14 set, Z load clear) leaves Z and the registers unchanged.
- R6: The MDR loads `mem_rdata` when its memory strobe and `mem_done` are both high. Otherwise it loads the bus under its bus strobe. If both strobes are set and `mem_done` is high, memory data wins. With `mem_done` low, the memory strobe alone leaves the MDR unchanged.
- R7: MAR loads from the bus under its strobe. `mem_addr` shows MAR and `mem_wdata` shows MDR.
- R8: The GPR load strobe writes the bus into the register named by the destination index. Every register, including register 0, is writable and is read back through the GPR source strobe.
- R9: PC and IR load from the bus under their strobes, and `pc_q` and `ir_q` show them.
- R10: `mem_rd` and `mem_wr` follow control bits 15 and 16 in the same cycle.
- R11: A synchronous active-high reset clears PC, IR, MAR, MDR, Y, Z, both flags and all general-purpose registers.
- R12: Every register load becomes visible on the outputs after the rising edge at which its strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 30 | Control word (R1 layout) |
| mem_rdata | input | 32 | Data returned by memory |
| mem_done | input | 1 | Memory transfer complete |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_wdata | output | 32 | Memory write data (MDR) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| pc_q | output | 32 | Program counter |
| ir_q | output | 32 | Instruction register |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| bus_mon | output | 32 | Internal bus value |

## Verification
The bus value and the memory strobes are combinational, so they are due in the same cycle the control word is applied. The bench drives each word at the falling edge and samples those outputs 1 time unit later. Every register, flag and memory-port register is due one rising edge after its strobe. The bench therefore advances its behavioural model at that edge and compares all registered outputs at the following falling edge. A full ALU operation spans three cycles: staging Y, capturing Z, and driving Z onto the bus. The bench reads results on the bus in that third cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  // source strobes (at most one active)
  localparam int B_PC_OUT      = 0;
  localparam int B_OFF_OUT     = 1;
  localparam int B_MDR_OUT     = 2;
  localparam int B_Z_OUT       = 3;
  localparam int B_GPR_OUT     = 4;
  localparam int NUM_SRC       = 5;
  // load strobes
  localparam int B_PC_IN       = 5;
  localparam int B_IR_IN       = 6;
  localparam int B_MAR_IN      = 7;
  localparam int B_MDR_IN_BUS  = 8;
  localparam int B_MDR_IN_MEM  = 9;
  localparam int B_Y_IN        = 10;
  localparam int B_Z_IN        = 11;
  localparam int B_GPR_IN      = 12;
  // misc
  localparam int B_SEL4        = 13;
  localparam int B_FLAG_EN     = 14;
  localparam int B_MEM_RD      = 15;
  localparam int B_MEM_WR      = 16;
  localparam int B_OP_LSB      = 17;
  localparam int OP_W          = 3;
  localparam int B_SRC_LSB     = B_OP_LSB + OP_W;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_INC  = 3'd4,
    ALU_INV  = 3'd5,
    ALU_SHL  = 3'd6,
    ALU_PASS = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic pc_in;
    logic ir_in;
    logic mar_in;
    logic mdr_in_bus;
    logic mdr_in_mem;
    logic y_in;
    logic z_in;
    logic gpr_in;
    logic sel4;
    logic flag_en;
  } load_ctl_t;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  output logic [DATA_W-1:0]   res
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (op)
      ALU_ADD:  res = opa + opb;
      ALU_SUB:  res = opa - opb;
      ALU_AND:  res = opa & opb;
      ALU_OR:   res = opa | opb;
      ALU_INC:  res = opb + ONE;
      ALU_INV:  res = ~opb;
      ALU_SHL:  res = {opb[DATA_W-2:0], 1'b0};
      default:  res = opb;
    endcase
  end
endmodule

// File: rtl/sbus_gpr_file.sv
module sbus_gpr_file #(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 32,
  localparam int IDX_W  = $clog2(NUM_GPR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_GPR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_GPR; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/sbus_bus_driver.sv
module sbus_bus_driver #(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0]        sel,
  input  logic [NUM_SRC*DATA_W-1:0] srcs,
  output logic [DATA_W-1:0]         bus
);
  logic [DATA_W-1:0] gated [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign gated[g] = srcs[g*DATA_W +: DATA_W] & {DATA_W{sel[g]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NUM_SRC; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 32,
  parameter int OFF_W   = 16,
  localparam int IDX_W  = $clog2(NUM_GPR),
  localparam int CTRL_W = B_SRC_LSB + 2*IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q,
  output logic              flag_z,
  output logic              flag_n,
  output logic [DATA_W-1:0] bus_mon
);
  localparam logic [DATA_W-1:0] CONST4 = DATA_W'(4);
  localparam int SRC_MSB = B_SRC_LSB + IDX_W - 1;
  localparam int DST_LSB = B_SRC_LSB + IDX_W;

  // control decode
  load_ctl_t          ld;
  alu_op_e            op;
  logic [IDX_W-1:0]   src_idx, dst_idx;
  logic [NUM_SRC-1:0] src_sel;

  assign ld = '{pc_in:      ctrl[B_PC_IN],
                ir_in:      ctrl[B_IR_IN],
                mar_in:     ctrl[B_MAR_IN],
                mdr_in_bus: ctrl[B_MDR_IN_BUS],
                mdr_in_mem: ctrl[B_MDR_IN_MEM],
                y_in:       ctrl[B_Y_IN],
                z_in:       ctrl[B_Z_IN],
                gpr_in:     ctrl[B_GPR_IN],
                sel4:       ctrl[B_SEL4],
                flag_en:    ctrl[B_FLAG_EN]};
  assign op      = alu_op_e'(ctrl[B_OP_LSB +: OP_W]);
  assign src_idx = ctrl[SRC_MSB:B_SRC_LSB];
  assign dst_idx = ctrl[CTRL_W-1:DST_LSB];
  assign src_sel = ctrl[NUM_SRC-1:0];

  // state
  logic [DATA_W-1:0] pc_r, ir_r, mar_r, mdr_r, y_r, z_q;
  logic              fz_r, fn_r;
  logic [DATA_W-1:0] gpr_rd, bus, off_ext, alu_a, alu_res;

  assign off_ext = {{(DATA_W-OFF_W){ir_r[OFF_W-1]}}, ir_r[OFF_W-1:0]};

  sbus_bus_driver #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_bus (
    .sel  (src_sel),
    .srcs ({gpr_rd, z_q, mdr_r, off_ext, pc_r}),
    .bus  (bus)
  );

  sbus_gpr_file #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_gpr (
    .clk     (clk),
    .rst     (rst),
    .we      (ld.gpr_in),
    .wr_idx  (dst_idx),
    .wr_data (bus),
    .rd_idx  (src_idx),
    .rd_data (gpr_rd)
  );

  assign alu_a = ld.sel4 ? CONST4 : y_r;

  sbus_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (op),
    .opa (alu_a),
    .opb (bus),
    .res (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_r  <= '0;
      ir_r  <= '0;
      mar_r <= '0;
      mdr_r <= '0;
      y_r   <= '0;
      z_q   <= '0;
      fz_r  <= 1'b0;
      fn_r  <= 1'b0;
    end else begin
      if (ld.pc_in)  pc_r  <= bus;
      if (ld.ir_in)  ir_r  <= bus;
      if (ld.mar_in) mar_r <= bus;
      if (ld.y_in)   y_r   <= bus;
      if (ld.z_in)   z_q   <= alu_res;
      if (ld.mdr_in_mem && mem_done) mdr_r <= mem_rdata;
      else if (ld.mdr_in_bus)        mdr_r <= bus;
      if (ld.flag_en) begin
        fz_r <= (alu_res == '0);
        fn_r <= alu_res[DATA_W-1];
      end
    end
  end

  assign mem_addr  = mar_r;
  assign mem_wdata = mdr_r;
  assign mem_rd    = ctrl[B_MEM_RD];
  assign mem_wr    = ctrl[B_MEM_WR];
  assign pc_q      = pc_r;
  assign ir_q      = ir_r;
  assign flag_z    = fz_r;
  assign flag_n    = fn_r;
  assign bus_mon   = bus;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk
  import sbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_done,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] pc_q,
  input logic              flag_z,
  input logic              flag_n,
  input logic [DATA_W-1:0] bus_mon,
  input logic [DATA_W-1:0] z_q
);
  // R2
  single_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl[NUM_SRC-1:0]));
  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[NUM_SRC-1:0] == '0) |-> (bus_mon == '0));
  // R4
  z_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[B_Z_OUT] |-> (bus_mon == z_q));
  // R4
  z_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[B_Z_IN] |=> $stable(z_q));
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[B_FLAG_EN] |=> $stable({flag_z, flag_n}));
  // R6
  mdr_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[B_MDR_IN_MEM] && mem_done) |=> (mem_wdata == $past(mem_rdata)));
  // R6
  mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[B_MDR_IN_BUS] && !(ctrl[B_MDR_IN_MEM] && mem_done)) |=> $stable(mem_wdata));
  // R7
  mar_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[B_MAR_IN] |=> (mem_addr == $past(bus_mon)));
  // R9
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[B_PC_IN] |=> (pc_q == $past(bus_mon)));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ctrl      (ctrl),
  .mem_rdata (mem_rdata),
  .mem_done  (mem_done),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pc_q      (pc_q),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .bus_mon   (bus_mon),
  .z_q       (z_q)
);

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
  import sbus_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CW = B_SRC_LSB + 10;
  typedef logic [CW-1:0] cw_t;

  localparam cw_t PC_OUT  = cw_t'(1) << B_PC_OUT;
  localparam cw_t OFF_OUT = cw_t'(1) << B_OFF_OUT;
  localparam cw_t MDR_OUT = cw_t'(1) << B_MDR_OUT;
  localparam cw_t Z_OUT   = cw_t'(1) << B_Z_OUT;
  localparam cw_t GPR_OUT = cw_t'(1) << B_GPR_OUT;
  localparam cw_t PC_IN   = cw_t'(1) << B_PC_IN;
  localparam cw_t IR_IN   = cw_t'(1) << B_IR_IN;
  localparam cw_t MAR_IN  = cw_t'(1) << B_MAR_IN;
  localparam cw_t MDRB_IN = cw_t'(1) << B_MDR_IN_BUS;
  localparam cw_t MDRM_IN = cw_t'(1) << B_MDR_IN_MEM;
  localparam cw_t Y_IN    = cw_t'(1) << B_Y_IN;
  localparam cw_t Z_IN    = cw_t'(1) << B_Z_IN;
  localparam cw_t GPR_IN  = cw_t'(1) << B_GPR_IN;
  localparam cw_t SEL4    = cw_t'(1) << B_SEL4;
  localparam cw_t FLG     = cw_t'(1) << B_FLAG_EN;
  localparam cw_t RD      = cw_t'(1) << B_MEM_RD;
  localparam cw_t WR      = cw_t'(1) << B_MEM_WR;

  function automatic cw_t opc(input int o);  return cw_t'(o) << B_OP_LSB;       endfunction
  function automatic cw_t src(input int i);  return cw_t'(i) << B_SRC_LSB;      endfunction
  function automatic cw_t dst(input int i);  return cw_t'(i) << (B_SRC_LSB+5);  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  cw_t         ctrl = '0;
  logic [31:0] mem_rdata = '0;
  logic        mem_done = 1'b0;
  logic [31:0] mem_addr, mem_wdata, pc_q, ir_q, bus_mon;
  logic        mem_rd, mem_wr, flag_z, flag_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_datapath dut_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .mem_rdata(mem_rdata), .mem_done(mem_done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_q(pc_q), .ir_q(ir_q), .flag_z(flag_z), .flag_n(flag_n), .bus_mon(bus_mon)
  );

  // behavioural reference model
  logic [31:0] m_gpr [32];
  logic [31:0] m_pc, m_ir, m_mar, m_mdr, m_y, m_z;
  logic        m_fz, m_fn;
  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  function automatic void model_reset();
    foreach (m_gpr[i]) m_gpr[i] = '0;
    m_pc = '0; m_ir = '0; m_mar = '0; m_mdr = '0; m_y = '0; m_z = '0;
    m_fz = 1'b0; m_fn = 1'b0;
  endfunction

  function automatic logic [31:0] model_bus(input cw_t c);
    if (c[B_PC_OUT])  return m_pc;
    if (c[B_OFF_OUT]) return {{16{m_ir[15]}}, m_ir[15:0]};
    if (c[B_MDR_OUT]) return m_mdr;
    if (c[B_Z_OUT])   return m_z;
    if (c[B_GPR_OUT]) return m_gpr[int'(c[B_SRC_LSB +: 5])];
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_alu(input int o, input logic [31:0] a, b);
    case (o)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return b + 32'd1;
      5: return ~b;
      6: return b << 1;
      default: return b;
    endcase
  endfunction

  function automatic void model_edge(input cw_t c, input logic [31:0] b,
                                     input logic [31:0] rd, input logic dn);
    logic [31:0] a, r;
    a = c[B_SEL4] ? 32'd4 : m_y;
    r = model_alu(int'(c[B_OP_LSB +: 3]), a, b);
    if (c[B_MDR_IN_MEM] && dn) m_mdr = rd;
    else if (c[B_MDR_IN_BUS])  m_mdr = b;
    if (c[B_PC_IN])  m_pc  = b;
    if (c[B_IR_IN])  m_ir  = b;
    if (c[B_MAR_IN]) m_mar = b;
    if (c[B_Y_IN])   m_y   = b;
    if (c[B_Z_IN])   m_z   = r;
    if (c[B_FLAG_EN]) begin m_fz = (r == 0); m_fn = r[31]; end
    if (c[B_GPR_IN]) m_gpr[int'(c[B_SRC_LSB+5 +: 5])] = b;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp_state(input string tag);
    chk(pc_q, m_pc, {tag, " pc"});
    chk(ir_q, m_ir, {tag, " ir"});
    chk(mem_addr, m_mar, {tag, " mar"});
    chk(mem_wdata, m_mdr, {tag, " mdr"});
    chk({30'd0, flag_z, flag_n}, {30'd0, m_fz, m_fn}, {tag, " flags"});
  endtask

  // one cycle: compare registered state, drive word, check bus, advance model
  task automatic step(input cw_t c, input logic [31:0] rd, input logic dn,
                      input bit has_exp, input logic [31:0] exp, input string tag);
    logic [31:0] eb;
    @(negedge clk);
    cmp_state(tag);
    ctrl = c; mem_rdata = rd; mem_done = dn;
    #1;
    eb = model_bus(c);
    chk(bus_mon, eb, {tag, " bus"});
    chk({30'd0, mem_rd, mem_wr}, {30'd0, c[B_MEM_RD], c[B_MEM_WR]}, "R10 mem strobes");
    if (has_exp) chk(bus_mon, exp, {tag, " const"});
    @(posedge clk);
    model_edge(c, eb, rd, dn);
  endtask

  task automatic s(input cw_t c, input string tag);
    step(c, 32'h0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic sx(input cw_t c, input logic [31:0] exp, input string tag);
    step(c, 32'h0, 1'b0, 1'b1, exp, tag);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    logic [31:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    sx(GPR_OUT | src(0),  32'h0, "R11 r0 after reset");
    sx(GPR_OUT | src(31), 32'h0, "R11 r31 after reset");
    sx('0, 32'h0, "R2 idle bus");

    // fetch: MAR<=PC, Z<=PC+4 ; PC<=Z, wait ; MDR<=mem ; IR<=MDR
    s(PC_OUT | MAR_IN | SEL4 | opc(0) | Z_IN | RD, "R7 fetch addr");
    step(Z_OUT | PC_IN | MDRM_IN | RD, 32'h0000_8005, 1'b0, 1'b1, 32'd4, "R6 wait no done");
    step(MDRM_IN | RD, 32'h0000_8005, 1'b1, 1'b0, 32'h0, "R6 mem capture");
    sx(MDR_OUT | IR_IN, 32'h0000_8005, "R9 ir load");
    sx(OFF_OUT | GPR_IN | dst(3), 32'hFFFF_8005, "R2 offset sign-extend");
    sx(GPR_OUT | src(3), 32'hFFFF_8005, "R8 r3 readback");
    chk(pc_q, 32'd4, "R9 pc after fetch");

    // load operands
    step(MDRM_IN, 32'h8000_0001, 1'b1, 1'b0, 32'h0, "R6 load");
    s(MDR_OUT | GPR_IN | dst(1), "R8 write r1");
    step(MDRM_IN, 32'h0000_00F0, 1'b1, 1'b0, 32'h0, "R6 load");
    s(MDR_OUT | GPR_IN | dst(2), "R8 write r2");

    // ADD: Y<=R1 ; Z<=Y+R2 ; R4<=Z
    s(GPR_OUT | src(1) | Y_IN, "R3 stage y");
    s(GPR_OUT | src(2) | opc(0) | Z_IN | FLG, "R3 add");
    sx(Z_OUT | GPR_IN | dst(4), 32'h8000_00F1, "R3 add result");
    chk({31'd0, flag_n}, 32'd1, "R5 negative flag");

    // compare: flags only, Z unchanged
    s(GPR_OUT | src(1) | opc(1) | FLG, "R5 compare");
    sx(Z_OUT, 32'h8000_00F1, "R5 compare leaves z");
    chk({31'd0, flag_z}, 32'd1, "R5 zero flag");

    s(GPR_OUT | src(2) | opc(2) | Z_IN, "R3 and");
    sx(Z_OUT, 32'h0, "R3 and result");
    s(GPR_OUT | src(2) | opc(3) | Z_IN | FLG, "R3 or");
    sx(Z_OUT, 32'h8000_00F1, "R3 or result");
    s(GPR_OUT | src(1) | opc(4) | Z_IN, "R3 inc");
    sx(Z_OUT, 32'h8000_0002, "R3 inc result");
    s(GPR_OUT | src(1) | opc(5) | Z_IN, "R3 inv");
    sx(Z_OUT, 32'h7FFF_FFFE, "R3 inv result");
    s(GPR_OUT | src(1) | opc(6) | Z_IN | FLG, "R3 shl");
    sx(Z_OUT, 32'h0000_0002, "R3 shl result");
    s(GPR_OUT | src(2) | SEL4 | opc(0) | Z_IN, "R3 sel4 add");
    sx(Z_OUT, 32'h0000_00F4, "R3 sel4 result");
    s(GPR_OUT | src(2) | opc(1), "R4 no z_in");
    sx(Z_OUT, 32'h0000_00F4, "R4 z held");

    // MDR priority and hold
    step(GPR_OUT | src(2) | MDRB_IN | MDRM_IN, 32'h0000_A5A5, 1'b1, 1'b0, 32'h0, "R6 both mem wins");
    sx(MDR_OUT, 32'h0000_A5A5, "R6 priority readback");
    step(GPR_OUT | src(2) | MDRB_IN | MDRM_IN, 32'h0000_A5A5, 1'b0, 1'b0, 32'h0, "R6 both no done");
    sx(MDR_OUT, 32'h0000_00F0, "R6 bus path");

    // store: MAR<=R4, MDR<=R1, write
    s(GPR_OUT | src(4) | MAR_IN, "R7 store addr");
    s(GPR_OUT | src(1) | MDRB_IN, "R7 store data");
    s(WR, "R10 write strobe");
    chk(mem_addr, 32'h8000_00F1, "R7 mem_addr");
    chk(mem_wdata, 32'h8000_0001, "R7 mem_wdata");

    // register 0 writable
    s(MDR_OUT | GPR_IN | dst(0), "R8 write r0");
    sx(GPR_OUT | src(0), 32'h8000_0001, "R8 r0 readback");

    // pseudo-random legal control words
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 200; k++) begin
      cw_t c;
      int so;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      so = int'(lfsr[2:0]) % 6;
      c = '0;
      if (so < 5) c[so] = 1'b1;
      c[16:5] = lfsr[14:3];
      c[CW-1:17] = lfsr[31:19];
      step(c, {lfsr[15:0], lfsr[31:16]}, lfsr[20], 1'b0, 32'h0, "R12 random");
    end

    // mid-run reset
    @(negedge clk);
    rst = 1'b1; ctrl = PC_IN | GPR_IN | OFF_OUT;
    @(posedge clk);
    model_reset();
    @(negedge clk) rst = 1'b0; ctrl = '0;
    sx(GPR_OUT | src(3), 32'h0, "R11 reset clears r3");
    s('0, "R11 state after reset");
    chk(pc_q, 32'h0, "R11 pc cleared");
    finish_up();
  end
endmodule